// File: doc/BRIEF.md
# Raster Timing Generator with Border Band and Display Window

This block produces the raster timing for one video output. A horizontal counter steps once per pixel clock up to a programmable line total. A vertical counter steps once per line up to a programmable field total. From the two counts the block decodes three things: a visible region framed by border start and stop positions, an inner display window placed inside that region, and the sync intervals outside it. Its outputs are horizontal and vertical sync, a border enable, the border colour, an active-pixel enable, and the window-relative x/y coordinate of the current pixel.

Software programs the block through a small word-wide write port. Every write lands in a shadow copy. The shadow set moves into the active set in the cycle that raises the vertical-blank event, so a reprogrammed mode starts on a clean field boundary. Several modes are available: horizontal pixel doubling, line doubling, interlaced fields of alternating length, and a blank control that turns the whole visible area into border. The vertical-blank event, with its field-parity flag, tells the rest of the system when it is safe to prepare the next frame.

Top module: `vtg_raster`

## Requirements
- R1: Writes go to shadow registers. The active set, including the border colour at address 6 (low 24 bits), takes the shadow values only at the clock edge that ends a cycle in which `vblank_o` is high. Any output that depends on a register written in mid-field keeps its old behaviour until that edge.
- R2: Address 0 holds the vertical total in bits 31:16 and the horizontal total in bits 15:0. A line lasts horizontal-total+1 clocks. A non-interlaced field lasts vertical-total+1 lines. `hsync_o` is high when the horizontal count lies outside [border start, border stop). `vsync_o` is high when the line count lies outside its own such range. The horizontal border word is address 1 and the vertical border word is address 2. Each holds its start in bits 31:16 and its stop in bits 15:0.
- R3: The window is the set of positions that lie inside the border region and also within [start, start+size) in each direction. Address 3 holds the window starts (vertical in 31:16, horizontal in 15:0). Address 4 holds the window sizes (height in 31:16, width in 15:0). `pix_en_o` is high inside the window. `border_en_o` is high in the rest of the border region, and there `border_rgb_o` shows the border colour; otherwise `border_rgb_o` is 0.
- R4: While the blank bit (bit 3 of the mode word at address 5) is set, `pix_en_o` stays low and `border_en_o` covers the whole border region.
- R5: `pix_x_o` equals the horizontal count minus the window horizontal start. When the pixel-doubling bit (bit 0 of the mode word) is set, it equals that difference divided by two. Outside the window it reads 0.
- R6: `pix_y_o` equals the line count minus the window vertical start. When the line-doubling bit (bit 1 of the mode word) is set, it equals that difference divided by two. Outside the window it reads 0.
- R7: With the interlace bit (bit 2 of the mode word) set, fields alternate. A field with parity 0 lasts vertical-total+1 lines and a field with parity 1 lasts vertical-total lines. `pix_y_o` becomes twice the R6 value plus the parity. `field_o` shows the parity and reads 0 when interlace is off.
- R8: `vblank_o` is high for exactly the one clock whose horizontal count is 0 and whose line count equals the vertical border stop.
- R9: While the enable bit (bit 4 of the mode word) is clear, `hsync_o`, `vsync_o`, `pix_en_o` and `border_en_o` are held low. The counters and `vblank_o` keep running.
- R10: After reset, every shadow and active register is 0 and both counters are 0. All sync and enable outputs are therefore low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync/blank interval |
| vsync_o | output | 1 | Vertical sync/blank interval |
| border_en_o | output | 1 | Current pixel shows the border colour |
| pix_en_o | output | 1 | Current pixel lies in the display window |
| border_rgb_o | output | COLOR_W | Border colour while border is shown, else 0 |
| pix_x_o | output | 16 | Window x coordinate |
| pix_y_o | output | 16 | Window y coordinate |
| vblank_o | output | 1 | One-clock vertical-blank event |
| field_o | output | 1 | Field parity in interlaced mode |

## Verification
The bench follows the counters across whole frames in every mode and goes after several corner cases.

Interlace is the first. A design that gave both fields the same length would move the vertical-blank event and misplace every line of the short field. It would also break the parity bit in the y coordinate.

The window is the second. One window starts before the border start, so the border must clip it. A design that decoded the window without the border would raise the pixel enable inside the sync interval, and its x coordinate would start at the wrong value. Doubling also rounds down: a design that rounded the wrong way, or doubled on the wrong axis, would repeat the wrong coordinates.

The shadow path and the blank and enable bits come last. A colour written in mid-field must not show until after the next event; a transparent register file would show it at once. With blank set, or enable clear, any window pixel that leaked through would be caught at the ports.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int FW = 16;

    typedef enum logic [2:0] {
        A_TOTAL  = 3'd0,
        A_HBORD  = 3'd1,
        A_VBORD  = 3'd2,
        A_WSTART = 3'd3,
        A_WSIZE  = 3'd4,
        A_MODE   = 3'd5,
        A_COLOUR = 3'd6
    } reg_addr_e;

    localparam int MB_LOWRES  = 0;
    localparam int MB_LINEDBL = 1;
    localparam int MB_ILACE   = 2;
    localparam int MB_BLANK   = 3;
    localparam int MB_ENABLE  = 4;

    typedef struct packed {
        logic [FW-1:0] h_total;
        logic [FW-1:0] v_total;
        logic [FW-1:0] hb_start;
        logic [FW-1:0] hb_stop;
        logic [FW-1:0] vb_start;
        logic [FW-1:0] vb_stop;
        logic [FW-1:0] wh_start;
        logic [FW-1:0] wv_start;
        logic [FW-1:0] w_width;
        logic [FW-1:0] w_height;
        logic          lowres;
        logic          linedbl;
        logic          ilace;
        logic          blank;
        logic          enable;
    } timing_t;

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int COLOR_W = 24,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               load,
    output timing_t            act_cfg,
    output logic [COLOR_W-1:0] act_colour
);

    localparam int HI = DATA_W / 2;

    typedef struct packed {
        timing_t            sh;
        timing_t            ac;
        logic [COLOR_W-1:0] sh_col;
        logic [COLOR_W-1:0] ac_col;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                A_TOTAL: begin
                    st_d.sh.v_total = wr_data[DATA_W-1:HI];
                    st_d.sh.h_total = wr_data[HI-1:0];
                end
                A_HBORD: begin
                    st_d.sh.hb_start = wr_data[DATA_W-1:HI];
                    st_d.sh.hb_stop  = wr_data[HI-1:0];
                end
                A_VBORD: begin
                    st_d.sh.vb_start = wr_data[DATA_W-1:HI];
                    st_d.sh.vb_stop  = wr_data[HI-1:0];
                end
                A_WSTART: begin
                    st_d.sh.wv_start = wr_data[DATA_W-1:HI];
                    st_d.sh.wh_start = wr_data[HI-1:0];
                end
                A_WSIZE: begin
                    st_d.sh.w_height = wr_data[DATA_W-1:HI];
                    st_d.sh.w_width  = wr_data[HI-1:0];
                end
                A_MODE: begin
                    st_d.sh.lowres  = wr_data[MB_LOWRES];
                    st_d.sh.linedbl = wr_data[MB_LINEDBL];
                    st_d.sh.ilace   = wr_data[MB_ILACE];
                    st_d.sh.blank   = wr_data[MB_BLANK];
                    st_d.sh.enable  = wr_data[MB_ENABLE];
                end
                A_COLOUR: st_d.sh_col = wr_data[COLOR_W-1:0];
                default: ;
            endcase
        end
        if (load) begin
            st_d.ac     = st_q.sh;
            st_d.ac_col = st_q.sh_col;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_cfg    = st_q.ac;
    assign act_colour = st_q.ac_col;

endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  timing_t       cfg,
    output logic [FW-1:0] h_cnt,
    output logic [FW-1:0] v_cnt,
    output logic          field,
    output logic          vblank
);

    typedef struct packed {
        logic [FW-1:0] h;
        logic [FW-1:0] v;
        logic          field;
    } cnt_t;

    cnt_t          st_d, st_q;
    logic [FW-1:0] last_v;
    logic          unused_cfg;

    assign unused_cfg = ^{cfg.hb_start, cfg.hb_stop, cfg.vb_start, cfg.wh_start,
                          cfg.wv_start, cfg.w_width, cfg.w_height, cfg.lowres,
                          cfg.linedbl, cfg.blank, cfg.enable};

    always_comb begin
        // odd-parity field of an interlaced pair is one line shorter
        if (cfg.ilace && st_q.field && (cfg.v_total != '0))
            last_v = cfg.v_total - 1'b1;
        else
            last_v = cfg.v_total;

        st_d = st_q;
        if (st_q.h >= cfg.h_total) begin
            st_d.h = '0;
            if (st_q.v >= last_v) begin
                st_d.v     = '0;
                st_d.field = cfg.ilace ? ~st_q.field : 1'b0;
            end else begin
                st_d.v = st_q.v + 1'b1;
            end
        end else begin
            st_d.h = st_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_cnt  = st_q.h;
    assign v_cnt  = st_q.v;
    assign field  = st_q.field;
    assign vblank = (st_q.h == '0) && (st_q.v == cfg.vb_stop);

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
    import vtg_pkg::*;
#(
    parameter int COLOR_W = 24
) (
    input  timing_t            cfg,
    input  logic [COLOR_W-1:0] colour,
    input  logic [FW-1:0]      h_cnt,
    input  logic [FW-1:0]      v_cnt,
    input  logic               field,
    output logic               hsync,
    output logic               vsync,
    output logic               pix_en,
    output logic               border_en,
    output logic [COLOR_W-1:0] border_rgb,
    output logic [FW-1:0]      pix_x,
    output logic [FW-1:0]      pix_y
);

    logic          h_in_b, v_in_b, h_in_w, v_in_w, win;
    logic [FW:0]   h_wend, v_wend;
    logic [FW-1:0] x_raw, y_raw, y_line, x_val, y_val;
    logic          unused_cfg;

    assign unused_cfg = ^{cfg.h_total, cfg.v_total};

    always_comb begin
        h_in_b = (h_cnt >= cfg.hb_start) && (h_cnt < cfg.hb_stop);
        v_in_b = (v_cnt >= cfg.vb_start) && (v_cnt < cfg.vb_stop);
        h_wend = {1'b0, cfg.wh_start} + {1'b0, cfg.w_width};
        v_wend = {1'b0, cfg.wv_start} + {1'b0, cfg.w_height};
        h_in_w = (h_cnt >= cfg.wh_start) && ({1'b0, h_cnt} < h_wend);
        v_in_w = (v_cnt >= cfg.wv_start) && ({1'b0, v_cnt} < v_wend);
        win    = h_in_b && v_in_b && h_in_w && v_in_w && !cfg.blank;

        x_raw  = h_cnt - cfg.wh_start;
        y_raw  = v_cnt - cfg.wv_start;
        x_val  = cfg.lowres  ? {1'b0, x_raw[FW-1:1]} : x_raw;
        y_line = cfg.linedbl ? {1'b0, y_raw[FW-1:1]} : y_raw;
        y_val  = cfg.ilace   ? {y_line[FW-2:0], field} : y_line;

        hsync      = cfg.enable && !h_in_b;
        vsync      = cfg.enable && !v_in_b;
        pix_en     = cfg.enable && win;
        border_en  = cfg.enable && h_in_b && v_in_b && !win;
        border_rgb = border_en ? colour : '0;
        pix_x      = pix_en ? x_val : '0;
        pix_y      = pix_en ? y_val : '0;
    end

endmodule

// File: rtl/vtg_raster.sv
module vtg_raster
    import vtg_pkg::*;
#(
    parameter int COLOR_W = 24,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               border_en_o,
    output logic               pix_en_o,
    output logic [COLOR_W-1:0] border_rgb_o,
    output logic [FW-1:0]      pix_x_o,
    output logic [FW-1:0]      pix_y_o,
    output logic               vblank_o,
    output logic               field_o
);

    timing_t            act_cfg;
    logic [COLOR_W-1:0] act_colour;
    logic [FW-1:0]      h_cnt, v_cnt;
    logic               field_q, vb_evt;

    vtg_regs #(.COLOR_W(COLOR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .load       (vb_evt),
        .act_cfg    (act_cfg),
        .act_colour (act_colour)
    );

    vtg_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg    (act_cfg),
        .h_cnt  (h_cnt),
        .v_cnt  (v_cnt),
        .field  (field_q),
        .vblank (vb_evt)
    );

    vtg_decode #(.COLOR_W(COLOR_W)) u_dec (
        .cfg        (act_cfg),
        .colour     (act_colour),
        .h_cnt      (h_cnt),
        .v_cnt      (v_cnt),
        .field      (field_q),
        .hsync      (hsync_o),
        .vsync      (vsync_o),
        .pix_en     (pix_en_o),
        .border_en  (border_en_o),
        .border_rgb (border_rgb_o),
        .pix_x      (pix_x_o),
        .pix_y      (pix_y_o)
    );

    assign vblank_o = vb_evt;
    assign field_o  = act_cfg.ilace & field_q;

endmodule

// File: rtl/vtg_raster_chk.sv
module vtg_raster_chk
    import vtg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          hsync,
    input logic          vsync,
    input logic          pix_en,
    input logic          border_en,
    input logic          vblank,
    input logic [FW-1:0] pix_x,
    input logic [FW-1:0] pix_y,
    input logic          act_en,
    input logic          act_blank,
    input logic          act_lowres,
    input logic [FW-1:0] act_htot
);

    AST_PIX_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |-> (!hsync && !vsync)); // R3

    AST_PIX_BORDER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_en && border_en)); // R3

    AST_BLANK_NO_PIX: assert property (@(posedge clk) disable iff (!rst_n)
        act_blank |-> !pix_en); // R4

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |-> !(hsync || vsync || pix_en || border_en)); // R9

    AST_X_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_lowres && $past(!act_lowres) && pix_en && $past(pix_en) && pix_x != '0)
        |-> (pix_x == $past(pix_x) + 1'b1)); // R5

    AST_X_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_lowres && pix_en && $past(pix_en) && pix_x != '0)
        |-> (pix_x == $past(pix_x) || pix_x == $past(pix_x) + 1'b1)); // R5

    AST_Y_HELD_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && $past(pix_en) && pix_x != '0) |-> (pix_y == $past(pix_y))); // R6

    AST_VBLANK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && act_htot != '0) |=> !vblank); // R8

endmodule

bind vtg_raster vtg_raster_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync      (hsync_o),
    .vsync      (vsync_o),
    .pix_en     (pix_en_o),
    .border_en  (border_en_o),
    .vblank     (vblank_o),
    .pix_x      (pix_x_o),
    .pix_y      (pix_y_o),
    .act_en     (act_cfg.enable),
    .act_blank  (act_cfg.blank),
    .act_lowres (act_cfg.lowres),
    .act_htot   (act_cfg.h_total)
);

// File: tb/vtg_raster_test.sv
`timescale 1ns/1ps
module vtg_raster_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync_o, vsync_o, border_en_o, pix_en_o, vblank_o, field_o;
    logic [23:0] border_rgb_o;
    logic [15:0] pix_x_o, pix_y_o;

    vtg_raster uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .hsync_o      (hsync_o),
        .vsync_o      (vsync_o),
        .border_en_o  (border_en_o),
        .pix_en_o     (pix_en_o),
        .border_rgb_o (border_rgb_o),
        .pix_x_o      (pix_x_o),
        .pix_y_o      (pix_y_o),
        .vblank_o     (vblank_o),
        .field_o      (field_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // bench copy of the programmed configuration
    int ht, vt, bsh, bph, bsv, bpv, wh, ww, wv, wht, col;
    bit lowres, ld, il, blank, en;
    // bench counter model
    int mh, mv, mf, col_act, col_pend;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d (h=%0d v=%0d f=%0d)",
                     tag, what, got, exp, mh, mv, mf);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic program_all();
        wr(3'd0, 32'((vt << 16) | ht));
        wr(3'd1, 32'((bsh << 16) | bph));
        wr(3'd2, 32'((bsv << 16) | bpv));
        wr(3'd3, 32'((wv << 16) | wh));
        wr(3'd4, 32'((wht << 16) | ww));
        wr(3'd5, {27'd0, en, blank, il, ld, lowres});
        wr(3'd6, 32'(col));
    endtask

    task automatic sync_up();
        int seen = 0;
        while (seen < 2) begin
            @(negedge clk);
            if (vblank_o) seen++;
        end
        mh = 0; mv = bpv; mf = int'(field_o);
        col_act = col; col_pend = col;
    endtask

    task automatic compare_now();
        bit hb, vb, hw, vw, win, e_pix, e_bord, e_vb;
        int ex, ey, ly;
        hb  = (mh >= bsh) && (mh < bph);
        vb  = (mv >= bsv) && (mv < bpv);
        hw  = (mh >= wh) && (mh < wh + ww);
        vw  = (mv >= wv) && (mv < wv + wht);
        win = hb && vb && hw && vw && !blank;
        e_pix  = en && win;
        e_bord = en && hb && vb && !win;
        e_vb   = (mh == 0) && (mv == bpv);
        ex = 0; ey = 0;
        if (e_pix) begin
            ex = lowres ? (mh - wh) / 2 : (mh - wh);
            ly = ld ? (mv - wv) / 2 : (mv - wv);
            ey = il ? (ly * 2 + mf) : ly;
        end
        chk(en ? "R2" : "R9", "hsync", int'(hsync_o), int'(en && !hb));
        chk(en ? "R2" : "R9", "vsync", int'(vsync_o), int'(en && !vb));
        chk(!en ? "R9" : (blank ? "R4" : "R3"), "pix_en", int'(pix_en_o), int'(e_pix));
        chk(!en ? "R9" : (blank ? "R4" : "R3"), "border_en", int'(border_en_o), int'(e_bord));
        chk("R1", "border_rgb", int'(border_rgb_o), e_bord ? col_act : 0);
        chk("R5", "pix_x", int'(pix_x_o), ex);
        chk(il ? "R7" : "R6", "pix_y", int'(pix_y_o), ey);
        chk("R8", "vblank", int'(vblank_o), int'(e_vb));
        if (e_vb) chk("R7", "field", int'(field_o), il ? mf : 0);
    endtask

    task automatic advance();
        int last;
        bit pulse;
        pulse = (mh == 0) && (mv == bpv);
        last  = (il && mf != 0 && vt != 0) ? vt - 1 : vt;
        if (mh >= ht) begin
            mh = 0;
            if (mv >= last) begin
                mv = 0;
                mf = il ? 1 - mf : 0;
            end else begin
                mv++;
            end
        end else begin
            mh++;
        end
        if (pulse) col_act = col_pend;
    endtask

    task automatic run(input int n, input int wr_at, input int wr_val);
        for (int i = 0; i < n; i++) begin
            compare_now();
            if (i == wr_at) begin
                wr_en = 1'b1; wr_addr = 3'd6; wr_data = 32'(wr_val);
                col_pend = wr_val;
            end else begin
                wr_en = 1'b0;
            end
            advance();
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input bit a_lowres, input bit a_ld, input bit a_il,
                            input bit a_blank, input bit a_en);
        lowres = a_lowres; ld = a_ld; il = a_il; blank = a_blank; en = a_en;
    endtask

    task automatic base_geometry();
        ht = 19; vt = 11; bsh = 2; bph = 18; bsv = 1; bpv = 10;
        wh = 4; ww = 10; wv = 3; wht = 5;
    endtask

    task automatic sweep(input int wr_at, input int wr_val);
        program_all();
        sync_up();
        run(520, wr_at, wr_val);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog (R1..R10 run incomplete): got %0d cycles expected under %0d",
                     cycles, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state, all registers and counters zero
        chk("R10", "hsync", int'(hsync_o), 0);
        chk("R10", "pix_en", int'(pix_en_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "vsync", int'(vsync_o), 0);
        chk("R10", "border_en", int'(border_en_o), 0);
        chk("R10", "border_rgb", int'(border_rgb_o), 0);
        chk("R10", "vblank", int'(vblank_o), 1);

        base_geometry();
        col = 24'h3a5c7e;
        set_mode(0, 0, 0, 0, 1); sweep(-1, 0);          // R2 R3 plain
        set_mode(1, 0, 0, 0, 1); sweep(-1, 0);          // R5 pixel doubling
        set_mode(0, 1, 0, 0, 1); sweep(-1, 0);          // R6 line doubling
        set_mode(0, 0, 1, 0, 1); sweep(-1, 0);          // R7 interlace
        set_mode(1, 1, 1, 0, 1); sweep(-1, 0);          // R7 interlace with doubling
        set_mode(0, 0, 0, 1, 1); sweep(-1, 0);          // R4 blank
        set_mode(0, 0, 0, 0, 0); sweep(-1, 0);          // R9 disabled
        wh = 1; ww = 30; wv = 0; wht = 20;              // R3 window clipped by border
        set_mode(1, 0, 0, 0, 1); sweep(-1, 0);
        base_geometry();
        col = 24'h102030;
        set_mode(0, 0, 0, 0, 1); sweep(100, 24'hf0e0d0); // R1 mid-field colour write

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule